// File: doc/BRIEF.md
# UART Receive Buffer with Idle Aging

This block sits between a serial deserializer and the processor side of a UART receiver. Each time the deserializer strobes in a character, the block stores the 8-bit data and that character's error flags in a 32-entry first-in first-out buffer. The processor pops entries through a read port. The head entry is always visible on the read word, and a data-ready flag shows whether anything is stored.

Three sticky status bits report buffer events:

- a fill-level bit, set when the stored count reaches a programmable threshold;
- an aging bit, set when stored data has gone unread for eight character times with no new arrival;
- a break bit, set when a character arrives marked as a break.

Each status bit is cleared by writing one to its position. Each has its own enable, and the interrupt output is the OR of every enabled status bit. A character that arrives while the buffer is full is discarded, and the newest stored entry is marked with an overrun flag.

Top module: `uart_rx_aging_fifo`

## Requirements
- R1: After reset the buffer is empty: `data_ready` is 0, `status` is 3'b000 and `irq` is 0.
- R2: Characters are read back in arrival order. `rd_word` shows the oldest entry, with data in bits [7:0], frame error in bit 8, parity error in bit 9, overrun in bit 10 and break in bit 11. A pulse on `rd_en` removes that entry.
- R3: `data_ready` is 1 whenever at least one character is stored, whatever the threshold.
- R4: `status[0]` (fill level) becomes 1 on the clock after the stored count first reaches a non-zero `rx_thresh`. With a threshold of 24 it stays 0 while 23 characters are stored.
- R5: `status[1]` (aging) is set on the 80th `bit_tick` (8 character times of 10 ticks) counted while the buffer is non-empty and no character arrives and none is read. It fires once per idle stretch.
- R6: The aging count restarts on every arrival and every read, and is held at zero while the buffer is empty, so an empty buffer never sets `status[1]`.
- R7: A character that arrives while 32 are stored and no read occurs is dropped. The overrun bit (bit 10) of the most recently stored entry is set, and the other entries are unchanged.
- R8: Writing with `clr_we` clears exactly the status bits that are 1 in `clr_bits`, and 3'b111 clears all of them. A condition still present in the same cycle sets its bit again, and the set takes priority.
- R9: `irq` is 1 exactly when some status bit is 1 together with its enable (`en_ready` for bit 0, `en_aging` for bit 1, `en_break` for bit 2).
- R10: `status[2]` (break) is set on the clock on which a character arrives with `rx_break` high, even if the character is dropped. This does not depend on `en_ready` or `en_aging`.
- R11: A read while the buffer is empty is ignored, and the next stored character reads back correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Character-received strobe from the deserializer |
| rx_data | input | 8 | Received character |
| rx_frame_err | input | 1 | Frame error for this character |
| rx_parity_err | input | 1 | Parity error for this character |
| rx_break | input | 1 | Character is a break condition |
| bit_tick | input | 1 | One pulse per serial bit period |
| rd_en | input | 1 | Pop the head entry |
| rd_word | output | 12 | Head entry: {break, overrun, parity, frame, data} |
| data_ready | output | 1 | At least one character stored |
| rx_thresh | input | 6 | Fill-level threshold |
| clr_we | input | 1 | Status clear strobe |
| clr_bits | input | 3 | Write-one-to-clear mask for status |
| status | output | 3 | {break, aging, fill level} sticky status |
| en_ready | input | 1 | Interrupt enable for fill level |
| en_aging | input | 1 | Interrupt enable for aging |
| en_break | input | 1 | Interrupt enable for break |
| irq | output | 1 | Interrupt request |

## Verification
A wrong pointer or count shows up on the first read after the fault: `rd_word` carries the wrong character, or `data_ready` stays up or drops early. A count that has slipped also moves the fill-level bit by one character, which is why the bench checks the 23/24 boundary. An aging counter that is off by one or restarts at the wrong time shows on `status[1]` one tick too early or too late, so the bench checks both the 79th and the 80th tick after every restart. A misplaced overrun mark appears only when the last entry of a full buffer is read, so a full buffer is drained entry by entry.

// File: rtl/uart_rx_aging_fifo.sv
module uart_rx_aging_fifo #(
  parameter int DEPTH          = 32,
  parameter int DATA_W         = 8,
  parameter int TICKS_PER_CHAR = 10,
  parameter int AGE_CHARS      = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rx_valid,
  input  logic [DATA_W-1:0]         rx_data,
  input  logic                      rx_frame_err,
  input  logic                      rx_parity_err,
  input  logic                      rx_break,
  input  logic                      bit_tick,
  input  logic                      rd_en,
  output logic [DATA_W+3:0]         rd_word,
  output logic                      data_ready,
  input  logic [$clog2(DEPTH):0]    rx_thresh,
  input  logic                      clr_we,
  input  logic [2:0]                clr_bits,
  output logic [2:0]                status,
  input  logic                      en_ready,
  input  logic                      en_aging,
  input  logic                      en_break,
  output logic                      irq
);
  localparam int AW        = $clog2(DEPTH);
  localparam int CW        = AW + 1;
  localparam int WW        = DATA_W + 4;
  localparam int AGE_LIMIT = TICKS_PER_CHAR * AGE_CHARS;
  localparam int GW        = $clog2(AGE_LIMIT + 1);

  logic [WW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [GW-1:0] age;

  wire empty = (count == '0);
  wire full  = (count == CW'(DEPTH));
  wire do_rd = rd_en && !empty;
  wire do_wr = rx_valid && (!full || do_rd);
  wire drop  = rx_valid && full && !do_rd;

  wire age_hit    = bit_tick && !empty && !rx_valid && !do_rd && (age == GW'(AGE_LIMIT - 1));
  wire ready_cond = !empty && (count >= rx_thresh);
  wire [2:0] set_ev = {rx_valid && rx_break, age_hit, ready_cond};

  always_ff @(posedge clk) begin
    if (do_wr)
      mem[wr_ptr] <= {rx_break, 1'b0, rx_parity_err, rx_frame_err, rx_data};
    else if (drop)
      mem[wr_ptr - 1'b1][DATA_W+2] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= rd_ptr + 1'b1;
      count <= count + CW'(do_wr) - CW'(do_rd);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || empty || rx_valid || do_rd)
      age <= '0;
    else if (bit_tick && age != GW'(AGE_LIMIT))
      age <= age + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~(clr_we ? clr_bits : 3'b000)) | set_ev;
  end

  assign rd_word    = mem[rd_ptr];
  assign data_ready = !empty;
  assign irq        = |(status & {en_break, en_aging, en_ready});
endmodule

module uart_rx_aging_fifo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       rx_break,
  input logic       data_ready,
  input logic       clr_we,
  input logic [2:0] clr_bits,
  input logic [2:0] status
);
  a_r3_push_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> data_ready);

  a_r11_empty_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_ready && !rx_valid) |=> !data_ready);

  a_r10_break_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_break) |=> status[2]);

  a_r8_clear_break: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_bits[2] && !(rx_valid && rx_break)) |=> !status[2]);

  a_r6_age_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(data_ready));

  a_r4_level_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(data_ready));
endmodule

bind uart_rx_aging_fifo uart_rx_aging_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_break(rx_break),
  .data_ready(data_ready), .clr_we(clr_we), .clr_bits(clr_bits), .status(status)
);

// File: tb/tb_uart_rx_aging_fifo.sv
module tb_uart_rx_aging_fifo;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic rx_valid = 0;
  logic [7:0] rx_data = 0;
  logic rx_frame_err = 0, rx_parity_err = 0, rx_break = 0;
  logic bit_tick = 0;
  logic rd_en = 0;
  logic [11:0] rd_word;
  logic data_ready;
  logic [5:0] rx_thresh = 6'd24;
  logic clr_we = 0;
  logic [2:0] clr_bits = 0;
  logic [2:0] status;
  logic en_ready = 0, en_aging = 0, en_break = 0;
  logic irq;

  int checks = 0;
  int fails = 0;

  // {break, parity, frame, data}
  localparam logic [10:0] VEC [6] = '{11'h041, 11'h1FF, 11'h2A5, 11'h400, 11'h73C, 11'h012};

  uart_rx_aging_fifo dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err), .rx_break(rx_break),
    .bit_tick(bit_tick), .rd_en(rd_en), .rd_word(rd_word), .data_ready(data_ready),
    .rx_thresh(rx_thresh), .clr_we(clr_we), .clr_bits(clr_bits), .status(status),
    .en_ready(en_ready), .en_aging(en_aging), .en_break(en_break), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic f, input logic p, input logic b);
    @(negedge clk);
    rx_valid = 1; rx_data = d; rx_frame_err = f; rx_parity_err = p; rx_break = b;
    @(negedge clk);
    rx_valid = 0; rx_frame_err = 0; rx_parity_err = 0; rx_break = 0;
  endtask

  task automatic pop_check(input string req, input logic [11:0] exp);
    chk(req, 32'(rd_word), 32'(exp));
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic clear(input logic [2:0] b);
    clr_we = 1; clr_bits = b;
    @(negedge clk);
    clr_we = 0; clr_bits = 0;
  endtask

  task automatic ticks(input int n);
    bit_tick = 1;
    repeat (n) @(negedge clk);
    bit_tick = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 data_ready", 32'(data_ready), 0);
    chk("R1 status", 32'(status), 0);
    chk("R1 irq", 32'(irq), 0);

    rd_en = 1; @(negedge clk); rd_en = 0;
    chk("R11 empty read", 32'(data_ready), 0);
    ticks(100);
    chk("R6 empty never ages", 32'(status[1]), 0);

    for (int i = 0; i < 6; i++) begin
      push(VEC[i][7:0], VEC[i][8], VEC[i][9], VEC[i][10]);
      chk("R3 data_ready after push", 32'(data_ready), 1);
    end
    for (int i = 0; i < 6; i++)
      pop_check("R2 order and layout", {VEC[i][10], 1'b0, VEC[i][9:0]});
    chk("R3 drained", 32'(data_ready), 0);
    chk("R10 break status only", 32'(status), 3'b100);
    chk("R9 irq masked", 32'(irq), 0);
    en_break = 1; @(negedge clk);
    chk("R9 irq break enabled", 32'(irq), 1);
    clear(3'b111);
    chk("R8 clear all", 32'(status), 0);
    chk("R9 irq after clear", 32'(irq), 0);
    en_break = 0;

    push(8'h55, 0, 0, 0);
    ticks(79);
    chk("R5 no aging at 79", 32'(status[1]), 0);
    ticks(1);
    chk("R5 aging at 80", 32'(status[1]), 1);
    chk("R9 aging masked", 32'(irq), 0);
    en_aging = 1; @(negedge clk);
    chk("R9 aging irq", 32'(irq), 1);
    en_aging = 0;
    clear(3'b010);
    chk("R8 clear aging", 32'(status[1]), 0);
    ticks(100);
    chk("R5 fires once", 32'(status[1]), 0);

    ticks(50);
    push(8'h66, 0, 0, 0);
    ticks(79);
    chk("R6 restart on arrival 79", 32'(status[1]), 0);
    ticks(1);
    chk("R6 restart on arrival 80", 32'(status[1]), 1);
    clear(3'b010);
    ticks(50);
    pop_check("R2 head after aging", 12'h055);
    ticks(79);
    chk("R6 restart on read 79", 32'(status[1]), 0);
    ticks(1);
    chk("R6 restart on read 80", 32'(status[1]), 1);
    clear(3'b010);
    pop_check("R2 second entry", 12'h066);
    chk("R11 drained", 32'(data_ready), 0);
    rd_en = 1; @(negedge clk); rd_en = 0;
    push(8'h77, 1, 0, 0);
    pop_check("R11 read after empty read", 12'h177);

    for (int i = 0; i < 32; i++) begin
      push(8'(i), 0, 0, 0);
      if (i == 22) begin
        @(negedge clk);
        chk("R4 below threshold", 32'(status[0]), 0);
      end
      if (i == 23) begin
        @(negedge clk);
        chk("R4 at threshold", 32'(status[0]), 1);
      end
    end
    push(8'hAA, 1, 0, 0);
    chk("R7 still full", 32'(data_ready), 1);
    clear(3'b001);
    chk("R8 set wins over clear", 32'(status[0]), 1);
    en_ready = 1; @(negedge clk);
    chk("R9 level irq", 32'(irq), 1);
    en_ready = 0;
    for (int i = 0; i < 32; i++)
      pop_check("R7 drain full", (i == 31) ? 12'h41F : 12'(i));
    chk("R7 empty after drain", 32'(data_ready), 0);
    clear(3'b001);
    chk("R8 clear level", 32'(status[0]), 0);

    en_break = 1;
    push(8'h00, 0, 0, 1);
    chk("R10 break status", 32'(status[2]), 1);
    chk("R10 break irq", 32'(irq), 1);
    chk("R10 others quiet", 32'(status[1:0]), 0);
    pop_check("R10 break word", 12'h800);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule